// File: doc/BRIEF.md
# Partitioned Crossbar Scheduler with Rotating Search Start

This block links four source partitions to four destination partitions through a 4x4 crossbar. Every source partition keeps one packet in a single-entry holding register, together with the index of the destination partition it is bound for and a timestamp. In each clock cycle, each destination partition picks at most one of the sources that hold a packet for it. Each pick is made on its own, and all four picks happen in parallel.

Every destination uses a fixed-priority search. The search does not start at source 0 for every destination. Destination d checks source d first, then d+1, and so on, wrapping modulo four. Because of this, no single source is favoured by all four destinations at once. The per-destination offset is a wiring choice, so it adds no logic.

A source whose packet wins sends that packet on the winning destination's output port in the next cycle. Its holding register is freed and can take a new packet in the same edge. A source that loses keeps its packet and refuses new input until it wins. This head-of-line stall is intended.

Top module: `pxb_xbar`

## Requirements
- R1: After reset every holding register is empty, every `dst_valid_o` bit is low and every `src_ready_o` bit is high.
- R2: In any cycle, each destination partition grants at most one source partition.
- R3: If at least one source holds a packet whose destination field equals d, then destination d grants one source in that cycle.
- R4: Destination d examines sources in the order d, d+1, d+2, d+3 (modulo 4). It grants the first source that holds a packet for d. The two-bit destination field of source s is `src_dest_i[2s+1:2s]`.
- R5: A grant made in cycle t appears on destination d's port in cycle t+1. `dst_valid_o[d]` is high, and the lane carries the granted packet's data, its timestamp, and the winning source index in `dst_src_o[2d+1:2d]`. `dst_valid_o[d]` is low in any cycle that follows a cycle with no grant for d.
- R6: A source that holds a packet and is not granted keeps that packet unchanged, keeps `src_ready_o` low, and ignores its load inputs.
- R7: `src_ready_o[s]` is high when source s is empty or is granted in that cycle. A load presented while ready is captured at the next edge.
- R8: A source partition receives at most one grant per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_valid_i | input | NP | Load strobe per source partition |
| src_dest_i | input | NP*2 | Destination partition index per source lane |
| src_ts_i | input | NP*TS_W | Packet timestamp per source lane |
| src_data_i | input | NP*DATA_W | Packet payload per source lane |
| src_ready_o | output | NP | Source can accept a packet at the next edge |
| dst_valid_o | output | NP | Packet delivered on this destination lane |
| dst_src_o | output | NP*2 | Index of the source that delivered the packet |
| dst_ts_o | output | NP*TS_W | Timestamp of the delivered packet |
| dst_data_o | output | NP*DATA_W | Payload of the delivered packet |

## Verification
The bench sweeps every assignment of idle or one of four destinations across the four sources, loaded together from an empty state. This covers full collisions on one destination, where a search that always started at source 0 or used the wrong wrap direction would pick the wrong winner. It also covers permutations, where an arbiter that was not work-conserving would leave a lane idle. Each sweep pattern drains over several cycles, which exposes a loser that dropped or altered its packet, or that accepted a new load while blocked. A long pseudo-random stream then loads sources in the same cycle they are granted. This catches a ready signal that ignored the grant, and output lanes that were late by a cycle or carried the wrong source index.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
    localparam int NP_DEF     = 4;
    localparam int DATA_W_DEF = 16;
    localparam int TS_W_DEF   = 8;

    // Source examined at search position k by destination d.
    function automatic int search_src(int d, int k, int n);
        return (d + k) % n;
    endfunction
endpackage

// File: rtl/pxb_src_slot.sv
module pxb_src_slot #(
    parameter int NP     = pxb_pkg::NP_DEF,
    parameter int DATA_W = pxb_pkg::DATA_W_DEF,
    parameter int TS_W   = pxb_pkg::TS_W_DEF,
    localparam int DW    = $clog2(NP)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ld_valid_i,
    input  logic [DW-1:0]     ld_dest_i,
    input  logic [TS_W-1:0]   ld_ts_i,
    input  logic [DATA_W-1:0] ld_data_i,
    input  logic              granted_i,
    output logic              ready_o,
    output logic              valid_o,
    output logic [DW-1:0]     dest_o,
    output logic [TS_W-1:0]   ts_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              vld;
        logic [DW-1:0]     dest;
        logic [TS_W-1:0]   ts;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  ready;

    always_comb begin
        ready  = !slot_q.vld || granted_i;
        slot_d = slot_q;
        if (granted_i) slot_d.vld = 1'b0;
        if (ready && ld_valid_i) begin
            slot_d.vld  = 1'b1;
            slot_d.dest = ld_dest_i;
            slot_d.ts   = ld_ts_i;
            slot_d.data = ld_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) slot_q <= '0;
        else         slot_q <= slot_d;
    end

    assign ready_o = ready;
    assign valid_o = slot_q.vld;
    assign dest_o  = slot_q.dest;
    assign ts_o    = slot_q.ts;
    assign data_o  = slot_q.data;
endmodule

// File: rtl/pxb_rot_arb.sv
module pxb_rot_arb #(
    parameter int NP    = pxb_pkg::NP_DEF,
    parameter int START = 0
) (
    input  logic [NP-1:0] req_i,
    output logic [NP-1:0] gnt_o
);
    logic [NP-1:0] gnt_d;
    logic          found;

    always_comb begin
        gnt_d = '0;
        found = 1'b0;
        for (int k = 0; k < NP; k++) begin
            int idx;
            idx = pxb_pkg::search_src(START, k, NP);
            if (!found && req_i[idx]) begin
                gnt_d[idx] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    assign gnt_o = gnt_d;
endmodule

// File: rtl/pxb_xbar.sv
module pxb_xbar #(
    parameter int NP     = pxb_pkg::NP_DEF,
    parameter int DATA_W = pxb_pkg::DATA_W_DEF,
    parameter int TS_W   = pxb_pkg::TS_W_DEF,
    localparam int DW    = $clog2(NP)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NP-1:0]      src_valid_i,
    input  logic [NP*DW-1:0]   src_dest_i,
    input  logic [NP*TS_W-1:0] src_ts_i,
    input  logic [NP*DATA_W-1:0] src_data_i,
    output logic [NP-1:0]      src_ready_o,
    output logic [NP-1:0]      dst_valid_o,
    output logic [NP*DW-1:0]   dst_src_o,
    output logic [NP*TS_W-1:0] dst_ts_o,
    output logic [NP*DATA_W-1:0] dst_data_o
);
    typedef struct packed {
        logic              vld;
        logic [DW-1:0]     src;
        logic [TS_W-1:0]   ts;
        logic [DATA_W-1:0] data;
    } lane_t;

    logic [NP-1:0]              slot_vld;
    logic [NP-1:0][DW-1:0]      slot_dest;
    logic [NP-1:0][TS_W-1:0]    slot_ts;
    logic [NP-1:0][DATA_W-1:0]  slot_data;
    logic [NP-1:0][NP-1:0]      req_m;     // [dest][src]
    logic [NP-1:0][NP-1:0]      gnt_m;     // [dest][src]
    logic [NP-1:0]              src_granted;
    lane_t [NP-1:0]             lane_d, lane_q;

    for (genvar s = 0; s < NP; s++) begin : g_src
        pxb_src_slot #(.NP(NP), .DATA_W(DATA_W), .TS_W(TS_W)) u_slot (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .ld_valid_i (src_valid_i[s]),
            .ld_dest_i  (src_dest_i[s*DW +: DW]),
            .ld_ts_i    (src_ts_i[s*TS_W +: TS_W]),
            .ld_data_i  (src_data_i[s*DATA_W +: DATA_W]),
            .granted_i  (src_granted[s]),
            .ready_o    (src_ready_o[s]),
            .valid_o    (slot_vld[s]),
            .dest_o     (slot_dest[s]),
            .ts_o       (slot_ts[s]),
            .data_o     (slot_data[s])
        );
    end

    always_comb begin
        for (int d = 0; d < NP; d++)
            for (int s = 0; s < NP; s++)
                req_m[d][s] = slot_vld[s] && (slot_dest[s] == DW'(d));
    end

    for (genvar d = 0; d < NP; d++) begin : g_dst
        pxb_rot_arb #(.NP(NP), .START(d)) u_arb (
            .req_i (req_m[d]),
            .gnt_o (gnt_m[d])
        );
    end

    always_comb begin
        src_granted = '0;
        for (int s = 0; s < NP; s++)
            for (int d = 0; d < NP; d++)
                src_granted[s] = src_granted[s] | gnt_m[d][s];
    end

    always_comb begin
        for (int d = 0; d < NP; d++) begin
            lane_d[d] = '0;
            for (int s = 0; s < NP; s++) begin
                if (gnt_m[d][s]) begin
                    lane_d[d].vld  = 1'b1;
                    lane_d[d].src  = DW'(s);
                    lane_d[d].ts   = slot_ts[s];
                    lane_d[d].data = slot_data[s];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lane_q <= '0;
        else         lane_q <= lane_d;
    end

    for (genvar d = 0; d < NP; d++) begin : g_out
        assign dst_valid_o[d]               = lane_q[d].vld;
        assign dst_src_o[d*DW +: DW]        = lane_q[d].src;
        assign dst_ts_o[d*TS_W +: TS_W]     = lane_q[d].ts;
        assign dst_data_o[d*DATA_W +: DATA_W] = lane_q[d].data;
    end
endmodule

// File: rtl/pxb_xbar_chk.sv
module pxb_xbar_chk #(
    parameter int NP   = pxb_pkg::NP_DEF,
    parameter int TS_W = pxb_pkg::TS_W_DEF
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic [NP-1:0][NP-1:0]  req_m,
    input logic [NP-1:0][NP-1:0]  gnt_m,
    input logic [NP-1:0]          slot_vld,
    input logic [NP-1:0][TS_W-1:0] slot_ts,
    input logic [NP-1:0]          src_granted,
    input logic [NP-1:0]          dst_valid_o
);
    logic [NP-1:0][NP-1:0] col_m;   // [src][dest]
    always_comb begin
        for (int s = 0; s < NP; s++)
            for (int d = 0; d < NP; d++)
                col_m[s][d] = gnt_m[d][s];
    end

    // Sources that destination d examines before reaching source s.
    function automatic logic [NP-1:0] ahead_mask(int d, int s);
        logic [NP-1:0] m;
        m = '0;
        for (int k = 0; k < NP; k++) begin
            int i;
            i = pxb_pkg::search_src(d, k, NP);
            if (i == s) break;
            m[i] = 1'b1;
        end
        return m;
    endfunction

    for (genvar d = 0; d < NP; d++) begin : g_d
        p_dst_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $onehot0(gnt_m[d]));
        p_work_cons_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (|req_m[d]) |-> (|gnt_m[d]));
        p_lane_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (|gnt_m[d]) |=> dst_valid_o[d]);
        p_lane_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(|gnt_m[d]) |=> !dst_valid_o[d]);
        for (genvar s = 0; s < NP; s++) begin : g_s
            p_search_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                gnt_m[d][s] |-> ((req_m[d] & ahead_mask(d, s)) == '0));
        end
    end

    for (genvar s = 0; s < NP; s++) begin : g_s
        p_src_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $onehot0(col_m[s]));
        p_loser_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (slot_vld[s] && !src_granted[s]) |=> (slot_vld[s] && $stable(slot_ts[s])));
    end
endmodule

bind pxb_xbar pxb_xbar_chk #(.NP(NP), .TS_W(TS_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_m       (req_m),
    .gnt_m       (gnt_m),
    .slot_vld    (slot_vld),
    .slot_ts     (slot_ts),
    .src_granted (src_granted),
    .dst_valid_o (dst_valid_o)
);

// File: tb/tb_pxb_xbar.sv
module tb_pxb_xbar;
    localparam int NP = 4, DW = 2, TS_W = 8, DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [NP-1:0]        src_valid_i = '0;
    logic [NP*DW-1:0]     src_dest_i = '0;
    logic [NP*TS_W-1:0]   src_ts_i = '0;
    logic [NP*DATA_W-1:0] src_data_i = '0;
    logic [NP-1:0]        src_ready_o, dst_valid_o;
    logic [NP*DW-1:0]     dst_src_o;
    logic [NP*TS_W-1:0]   dst_ts_o;
    logic [NP*DATA_W-1:0] dst_data_o;

    pxb_xbar #(.NP(NP), .DATA_W(DATA_W), .TS_W(TS_W)) dut (
        .clk_i(clk), .rst_ni(rst_n),
        .src_valid_i(src_valid_i), .src_dest_i(src_dest_i),
        .src_ts_i(src_ts_i), .src_data_i(src_data_i),
        .src_ready_o(src_ready_o), .dst_valid_o(dst_valid_o),
        .dst_src_o(dst_src_o), .dst_ts_o(dst_ts_o), .dst_data_o(dst_data_o)
    );

    // Bench-side reference state
    bit m_vld [NP];  int m_dest [NP];  int m_ts [NP];  int m_data [NP];
    bit e_vld [NP];  int e_src [NP];   int e_ts [NP];  int e_data [NP];
    bit i_vld [NP];  int i_dest [NP];  int i_ts [NP];  int i_data [NP];
    int checks = 0, fails = 0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Called just after a falling edge; ends just after the next falling edge.
    task automatic step();
        bit g [NP][NP];
        bit granted [NP];
        bit rdy [NP];
        for (int d = 0; d < NP; d++) begin
            chk(dst_valid_o[d] == e_vld[d], "R5", $sformatf("dst%0d valid", d),
                dst_valid_o[d], e_vld[d]);
            if (e_vld[d]) begin
                chk(dst_src_o[d*DW +: DW] == e_src[d], "R4", $sformatf("dst%0d winner", d),
                    dst_src_o[d*DW +: DW], e_src[d]);
                chk(dst_ts_o[d*TS_W +: TS_W] == e_ts[d], "R5", $sformatf("dst%0d ts", d),
                    dst_ts_o[d*TS_W +: TS_W], e_ts[d]);
                chk(dst_data_o[d*DATA_W +: DATA_W] == e_data[d], "R6", $sformatf("dst%0d data", d),
                    dst_data_o[d*DATA_W +: DATA_W], e_data[d]);
            end
        end
        for (int s = 0; s < NP; s++) granted[s] = 1'b0;
        for (int d = 0; d < NP; d++) begin
            bit found;
            found = 1'b0;
            e_vld[d] = 1'b0;
            for (int k = 0; k < NP; k++) begin
                int s;
                s = (d + k) % NP;
                g[d][s] = 1'b0;
                if (!found && m_vld[s] && m_dest[s] == d) begin
                    found = 1'b1; g[d][s] = 1'b1; granted[s] = 1'b1;
                    e_vld[d] = 1'b1; e_src[d] = s; e_ts[d] = m_ts[s]; e_data[d] = m_data[s];
                end
            end
        end
        for (int s = 0; s < NP; s++) begin
            rdy[s] = !m_vld[s] || granted[s];
            chk(src_ready_o[s] == rdy[s], rdy[s] ? "R7" : "R6",
                $sformatf("src%0d ready", s), src_ready_o[s], rdy[s]);
            src_valid_i[s]                  = i_vld[s];
            src_dest_i[s*DW +: DW]          = DW'(i_dest[s]);
            src_ts_i[s*TS_W +: TS_W]        = TS_W'(i_ts[s]);
            src_data_i[s*DATA_W +: DATA_W]  = DATA_W'(i_data[s]);
            if (granted[s]) m_vld[s] = 1'b0;
            if (rdy[s] && i_vld[s]) begin
                m_vld[s] = 1'b1; m_dest[s] = i_dest[s] % NP;
                m_ts[s] = i_ts[s] % (1 << TS_W); m_data[s] = i_data[s] % (1 << DATA_W);
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit busy();
        for (int s = 0; s < NP; s++) if (m_vld[s] || e_vld[s]) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R5 watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int lfsr;
        for (int s = 0; s < NP; s++) begin
            m_vld[s] = 0; e_vld[s] = 0; i_vld[s] = 0; i_dest[s] = 0; i_ts[s] = 0; i_data[s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(dst_valid_o == '0, "R1", "dst_valid after reset", dst_valid_o, 0);
        chk(src_ready_o == '1, "R1", "src_ready after reset", src_ready_o, 15);

        // R2 R3 R4 R8: every idle/destination combination, loaded together, then drained
        for (int p = 0; p < 625; p++) begin
            int code;
            code = p;
            for (int s = 0; s < NP; s++) begin
                i_vld[s]  = (code % 5) != 0;
                i_dest[s] = (code % 5 == 0) ? 0 : (code % 5) - 1;
                i_ts[s]   = (p + 3 * s) & 8'hFF;
                i_data[s] = (p * 4 + s) & 16'hFFFF;
                code      = code / 5;
            end
            step();
            for (int s = 0; s < NP; s++) i_vld[s] = 1'b0;
            while (busy()) step();
        end

        // R6 R7: continuous loading including load-while-granted
        lfsr = 16'hACE1;
        for (int c = 0; c < 3000; c++) begin
            for (int s = 0; s < NP; s++) begin
                lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
                i_vld[s]  = (lfsr & 3) != 0;
                i_dest[s] = (lfsr >> 2) & 3;
                i_ts[s]   = (lfsr >> 4) & 8'hFF;
                i_data[s] = lfsr ^ (c << 2) ^ s;
            end
            step();
        end
        for (int s = 0; s < NP; s++) i_vld[s] = 1'b0;
        while (busy()) step();
        step();
        summary();
    end
endmodule